// File: doc/BRIEF.md
# Compressed Instruction Packet Dispatcher

This block sits between instruction fetch and the functional-unit decoders of a six-issue statically scheduled processor. Fetch hands it 256-bit packets in which 16-bit and 32-bit instructions are packed back to back. No empty operations are stored. The dispatcher finds the instruction boundaries and works out which consecutive instructions form one issue group. It then routes each instruction to one of six unit lanes: two clusters, x and y, each with an arithmetic (A), a multiply (M) and a data/branch (D) position. The encoding has no parallel bit and no unit-select field. Both the grouping and the target lane follow from the 4-bit type field and the cluster bit.

Halfwords not yet consumed stay in an internal queue. The next packet is appended behind them, so an issue group, or a single 32-bit instruction, may span two fetch packets. Fetch delivers packets over a valid/ready handshake. `in_ready` is low whenever the queue could not absorb a whole packet, and a packet offered while `in_ready` is low waits, unchanged, with `in_valid` held high. Groups leave through a registered valid/ready stage. Once `out_valid` is high, the lane flags and words stay frozen until `out_ready` is seen. Fetch must keep `in_valid` high for as long as it has packets. Dropping it is read as the end of the stream, and whatever whole instructions are queued are then issued. A `flush` pulse empties the queue and the output stage on a branch redirect.

Top module: `vliw_dispatch`

## Requirements
- R1: The type field of an instruction is bits 15:12 of its first halfword. When bits 15:14 are 2'b11 the instruction is 32 bits long (first halfword plus the next one); any other value makes it 16 bits long.
- R2: Unit class of a 16-bit instruction comes from type bits 15:14: 00 gives A, 01 gives M, 10 gives D. A 32-bit instruction uses bits 13:12: 00 gives A, 01 gives M, 10 or 11 gives D.
- R3: Bit 11 of the first halfword picks the cluster (0 = x, 1 = y). The lane index is cluster*3 + class (A=0, M=1, D=2), and lane k uses `out_lane_word[32k+31:32k]`. That word holds the first halfword in bits 15:0 and, for a 32-bit instruction, the second halfword in bits 31:16 (zero otherwise).
- R4: An issue group takes consecutive instructions and stops just before the first one whose lane is already occupied in the group, or after six instructions.
- R5: Halfword k of a packet is `in_pkt[16k+15:16k]`, consumed in ascending k. The halfwords of a new packet follow the queued ones directly, so groups and 32-bit instructions continue across packet boundaries.
- R6: A lane without an instruction in the presented group has its valid flag at 0 and its word at zero (an empty operation). A presented group always has at least one lane valid.
- R7: `in_ready` is high exactly when the queue holds no more than BUF_HW-16 halfwords; a packet is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R8: While `out_valid` is high and `out_ready` low, `out_valid`, `out_lane_vld` and `out_lane_word` hold their values.
- R9: While `in_valid` is low, queued whole instructions issue as groups even when no lane conflict ends them. The first half of a 32-bit instruction whose second half has not arrived is never issued.
- R10: A cycle with `flush` high empties the queue and the output stage by the next cycle, and a packet offered in that cycle is dropped.
- R11: After reset `out_valid` is 0, no lane is valid, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all queued and presented instructions |
| in_valid | input | 1 | Fetch packet offered |
| in_ready | output | 1 | Queue can take a whole packet |
| in_pkt | input | 256 | Fetch packet, halfword k at bits 16k+15:16k |
| out_valid | output | 1 | Issue group presented |
| out_ready | input | 1 | Downstream takes the group |
| out_lane_vld | output | 6 | Per-lane valid, lane = cluster*3 + class |
| out_lane_word | output | 192 | Per-lane instruction word, 32 bits per lane |

## Verification
The bench targets the lane conflict that ends a group and the cap at six instructions. A design that got either wrong would merge instructions meant for different cycles or drop one. It also checks a 32-bit instruction split over two packets; a design that mishandled it would issue a half instruction or misalign every later instruction. Class code 11 on a 32-bit instruction is included, which a design with a faulty class decode would send to the wrong lane. Under a stall, the first point is back-pressure: a queue that overran would lose halfwords. The second is the output hold, where a group that changed before acceptance would reach the decoders garbled. End-of-stream draining and flush are covered too. A design that issued before the second half arrived, or that kept stale words after a redirect, produces groups that differ from the bench's own grouping model.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  localparam int HW_W   = 16;
  localparam int WORD_W = 32;
  localparam int CLUST  = 2;
  localparam int CLASSES = 3;
  localparam int LANES  = CLUST * CLASSES;

  typedef enum logic [1:0] {
    UC_A = 2'd0,
    UC_M = 2'd1,
    UC_D = 2'd2
  } ucls_e;

  // 32-bit form when the two top type bits are both set
  function automatic logic hw_is_long(input logic [HW_W-1:0] h);
    return h[15:14] == 2'b11;
  endfunction

  function automatic ucls_e hw_class(input logic [HW_W-1:0] h);
    logic [1:0] sel;
    sel = hw_is_long(h) ? h[13:12] : h[15:14];
    case (sel)
      2'b00:   return UC_A;
      2'b01:   return UC_M;
      default: return UC_D;
    endcase
  endfunction

  function automatic logic [2:0] hw_lane(input logic [HW_W-1:0] h);
    logic [2:0] base;
    base = h[11] ? 3'd3 : 3'd0;
    return base + {1'b0, hw_class(h)};
  endfunction
endpackage

// File: rtl/vdisp_hw_buffer.sv
module vdisp_hw_buffer #(
  parameter int PKT_HW = 16,
  parameter int BUF_HW = 32,
  localparam int CNT_W = $clog2(BUF_HW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   acc,
  input  logic [PKT_HW*16-1:0]   pkt,
  input  logic [CNT_W-1:0]       cons,
  output logic [BUF_HW*16-1:0]   q_flat,
  output logic [CNT_W-1:0]       count
);
  logic [BUF_HW*16-1:0] mem_q, mem_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;

  // shift out consumed halfwords, append packet behind the survivors
  always_comb begin
    int keep;
    int nc;
    keep = int'(cnt_q) - int'(cons);
    mem_d = '0;
    for (int i = 0; i < BUF_HW; i++) begin
      if (i < keep) begin
        if (i + int'(cons) < BUF_HW)
          mem_d[i*16 +: 16] = mem_q[(i + int'(cons))*16 +: 16];
      end else if (acc && (i - keep) < PKT_HW) begin
        mem_d[i*16 +: 16] = pkt[(i - keep)*16 +: 16];
      end
    end
    nc = keep + (acc ? PKT_HW : 0);
    cnt_d = CNT_W'(nc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign q_flat = mem_q;
  assign count  = cnt_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= BUF_HW);

  assert_cons_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cons) <= int'(cnt_q));

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/vdisp_group_former.sv
module vdisp_group_former
  import vdisp_pkg::*;
#(
  parameter int BUF_HW = 32,
  localparam int CNT_W = $clog2(BUF_HW + 1)
) (
  input  logic [BUF_HW*16-1:0]     q_flat,
  input  logic [CNT_W-1:0]         count,
  input  logic                     drain_ok,
  output logic                     grp_ready,
  output logic [CNT_W-1:0]         grp_len,
  output logic [LANES-1:0]         grp_vld,
  output logic [LANES*WORD_W-1:0]  grp_words
);
  always_comb begin
    logic [LANES-1:0] taken;
    logic             stop;
    logic             conflict;
    logic [15:0]      h0;
    logic [15:0]      h1;
    logic [2:0]       ln;
    int               off;
    int               len;
    taken = '0;
    stop = 1'b0;
    conflict = 1'b0;
    h0 = '0;
    h1 = '0;
    ln = '0;
    off = 0;
    len = 0;
    grp_words = '0;
    for (int j = 0; j < LANES; j++) begin
      if (!stop) begin
        if (off >= int'(count)) begin
          stop = 1'b1;                       // queue exhausted
        end else begin
          h0  = q_flat[off*16 +: 16];
          len = hw_is_long(h0) ? 2 : 1;
          if (off + len > int'(count)) begin
            stop = 1'b1;                     // second half not yet here
          end else begin
            ln = hw_lane(h0);
            if (taken[ln]) begin
              stop = 1'b1;
              conflict = 1'b1;
            end else begin
              h1 = (len == 2) ? q_flat[(off+1)*16 +: 16] : 16'h0;
              taken[ln] = 1'b1;
              grp_words[int'(ln)*WORD_W +: WORD_W] = {h1, h0};
              off = off + len;
            end
          end
        end
      end
    end
    grp_vld   = taken;
    grp_len   = CNT_W'(off);
    grp_ready = conflict || (&taken) || (drain_ok && (|taken));
  end
endmodule

// File: rtl/vdisp_issue_reg.sv
module vdisp_issue_reg
  import vdisp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     load,
  input  logic [LANES-1:0]         grp_vld,
  input  logic [LANES*WORD_W-1:0]  grp_words,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [LANES-1:0]         out_lane_vld,
  output logic [LANES*WORD_W-1:0]  out_lane_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_lane_vld  <= '0;
      out_lane_word <= '0;
    end else if (flush) begin
      out_valid     <= 1'b0;
      out_lane_vld  <= '0;
      out_lane_word <= '0;
    end else if (load) begin
      out_valid     <= 1'b1;
      out_lane_vld  <= grp_vld;
      out_lane_word <= grp_words;
    end else if (out_valid && out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_lane_vld) && $stable(out_lane_word)));

  assert_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lane_vld != '0));

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  for (genvar k = 0; k < LANES; k++) begin : g_nop
    assert_nop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_lane_vld[k]) |-> (out_lane_word[k*WORD_W +: WORD_W] == '0));
  end
endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vdisp_pkg::*;
#(
  parameter int PKT_W  = 256,
  parameter int BUF_HW = 2 * (PKT_W / 16),
  localparam int PKT_HW = PKT_W / 16,
  localparam int CNT_W  = $clog2(BUF_HW + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PKT_W-1:0]         in_pkt,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES-1:0]         out_lane_vld,
  output logic [LANES*WORD_W-1:0]  out_lane_word
);
  logic [BUF_HW*16-1:0]     q_flat;
  logic [CNT_W-1:0]         count;
  logic [CNT_W-1:0]         cons;
  logic                     acc;
  logic                     load;
  logic                     grp_ready;
  logic [CNT_W-1:0]         grp_len;
  logic [LANES-1:0]         grp_vld;
  logic [LANES*WORD_W-1:0]  grp_words;

  assign in_ready = int'(count) <= (BUF_HW - PKT_HW);
  assign acc      = in_valid && in_ready && !flush;
  assign load     = grp_ready && (!out_valid || out_ready) && !flush;
  assign cons     = load ? grp_len : '0;

  vdisp_hw_buffer #(.PKT_HW(PKT_HW), .BUF_HW(BUF_HW)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .acc    (acc),
    .pkt    (in_pkt),
    .cons   (cons),
    .q_flat (q_flat),
    .count  (count)
  );

  vdisp_group_former #(.BUF_HW(BUF_HW)) u_form (
    .q_flat    (q_flat),
    .count     (count),
    .drain_ok  (!in_valid),
    .grp_ready (grp_ready),
    .grp_len   (grp_len),
    .grp_vld   (grp_vld),
    .grp_words (grp_words)
  );

  vdisp_issue_reg u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .load          (load),
    .grp_vld       (grp_vld),
    .grp_words     (grp_words),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_lane_vld  (out_lane_vld),
    .out_lane_word (out_lane_word)
  );

  // a group taken from the queue never exceeds what is queued
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (int'(grp_len) <= int'(count) && grp_len != '0));

  // a group of six instructions spans at most twelve halfwords
  assert_len_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (int'(grp_len) <= 2 * LANES));
endmodule

// File: tb/tb_vliw_dispatch.sv
`timescale 1ns/1ps
module tb_vliw_dispatch;
  localparam int MAXHW = 512;
  localparam int MAXG  = 512;
  localparam int NOBRK = 1 << 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_pkt = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [5:0]   out_lane_vld;
  logic [191:0] out_lane_word;

  vliw_dispatch dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lane_vld(out_lane_vld), .out_lane_word(out_lane_word)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;
  int cyc_all = 0;
  bit done = 0;

  logic [15:0]  hw_mem [MAXHW];
  logic [5:0]   exp_v  [MAXG];
  logic [191:0] exp_w  [MAXG];
  int ng, ng_pre;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] got, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired: got %0d cycles expected fewer", cyc_all);
      finish_run();
    end
  end

  // lane from requirements R1-style field rules, written independently
  function automatic int lane_of(input logic [15:0] h);
    int c;
    if (h[15] && h[14]) c = h[13] ? 2 : (h[12] ? 1 : 0);   // R2 32-bit: 11 -> D
    else if (!h[15] && !h[14]) c = 0;
    else if (!h[15]) c = 1;
    else c = 2;
    return (h[11] ? 3 : 0) + c;                           // R3 cluster bit
  endfunction

  function automatic logic [15:0] mk(input bit lng, input int cls, input bit cl, input int tag);
    logic [15:0] h;
    h[10:0] = 11'(tag);
    h[11] = cl;
    if (lng) h[15:12] = {2'b11, 2'(cls)};
    else     h[15:12] = {2'(cls), 2'(tag >> 3)};
    return h;
  endfunction

  // mode 0 mixed, 1 mostly long, 2 only cluster x A/M (many conflicts)
  task automatic gen_stream(input int npk, input int mode);
    int n, cls;
    bit lng, cl;
    n = 0;
    while (n < npk*16) begin
      case (mode)
        1: lng = ($urandom % 4) != 0;
        2: lng = ($urandom % 4) == 0;
        default: lng = ($urandom % 2) != 0;
      endcase
      if (n == npk*16 - 1) lng = 0;
      cls = (mode == 2) ? int'($urandom % 2) : int'($urandom % (lng ? 4 : 3));
      cl  = (mode == 2) ? 1'b0 : 1'($urandom % 2);
      hw_mem[n] = mk(lng, cls, cl, int'($urandom % 2048));
      n++;
      if (lng) begin
        hw_mem[n] = 16'($urandom);
        n++;
      end
    end
  endtask

  task automatic build_groups(input int nhw, input int brk);
    int p, cnt, len, ln, fe;
    logic [5:0] tk;
    logic [15:0] h;
    ng = 0; ng_pre = 0; p = 0;
    while (p < nhw) begin
      tk = '0; cnt = 0; fe = 0;
      exp_w[ng] = '0;
      while (p < nhw && cnt < 6) begin
        h = hw_mem[p];
        len = (h[15:14] == 2'b11) ? 2 : 1;
        if (cnt > 0 && fe <= brk && p + len > brk) break;
        ln = lane_of(h);
        if (tk[ln]) break;
        tk[ln] = 1'b1;
        exp_w[ng][ln*32 +: 32] = {(len == 2) ? hw_mem[p+1] : 16'h0, h};
        if (cnt == 0) fe = p + len;
        p += len;
        cnt++;
      end
      exp_v[ng] = tk;
      if (fe <= brk) ng_pre++;
      ng++;
    end
  endtask

  task automatic run_stream(input int npk, input int brk, input int hold, input string tag);
    int p, gi, cyc, pacc, idle;
    bit acc_prev, allowed, held;
    logic [5:0] sv_v;
    logic [191:0] sv_w;
    build_groups(npk*16, brk);
    p = 0; gi = 0; cyc = 0; pacc = 0; idle = 0; acc_prev = 0; held = 0;
    sv_v = '0; sv_w = '0;
    while (gi < ng && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (acc_prev) p++;
      allowed = (p < npk) && (p*16 < brk || gi >= ng_pre);
      if (brk != NOBRK && gi >= ng_pre && idle < 4 && p < npk) begin
        if (idle >= 1)   // R9: trailing half of a split 32-bit must wait
          chk(!out_valid, "R9", {tag, " split instruction held back"},
              192'(out_valid), 192'(0));
        idle++;
        allowed = 0;
      end
      in_valid = allowed;
      for (int k = 0; k < 16; k++)
        in_pkt[k*16 +: 16] = allowed ? hw_mem[p*16 + k] : 16'h0;   // R5 order
      acc_prev = allowed && in_ready;
      if (acc_prev) pacc++;
      if (held)
        chk(out_valid && out_lane_vld == sv_v && out_lane_word == sv_w, "R8",
            {tag, " group held while stalled"}, out_lane_word, sv_w);
      out_ready = (cyc <= hold) ? 1'b0 : (($urandom % 4) != 0);
      if (hold > 0 && cyc == hold)
        chk(pacc == 2 && !in_ready, "R7", {tag, " packets taken under stall"},
            192'(pacc), 192'(2));
      if (out_valid && out_ready) begin
        chk(out_lane_vld == exp_v[gi], "R4", {tag, " lane flags"},
            192'(out_lane_vld), 192'(exp_v[gi]));
        chk(out_lane_word == exp_w[gi], "R6", {tag, " lane words"},
            out_lane_word, exp_w[gi]);
        gi++;
      end
      held = out_valid && !out_ready;
      sv_v = out_lane_vld;
      sv_w = out_lane_word;
    end
    chk(gi == ng, "R5", {tag, " all groups issued"}, 192'(gi), 192'(ng));
    @(negedge clk);
    in_valid = 0;
    out_ready = 0;
    in_pkt = '0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    #35;
    // R11: reset state
    chk(!out_valid && out_lane_vld == 6'h0, "R11", "outputs idle in reset",
        192'(out_valid), 192'(0));
    chk(in_ready, "R11", "ready in reset", 192'(in_ready), 192'(1));
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R11", "idle after reset",
        192'({out_valid, in_ready}), 192'(1));

    // R4: every instruction on cluster x A lane -> one per group
    for (int i = 0; i < 16; i++) hw_mem[i] = mk(0, 0, 0, i);
    run_stream(1, NOBRK, 0, "same-lane");

    // R1 R2 R3 R4 R5: six long instructions fill all lanes (one with class 11),
    // then shorts, then a long instruction split over the packet boundary
    hw_mem[0]  = mk(1, 2, 1, 5);  hw_mem[1]  = 16'hA001;
    hw_mem[2]  = mk(1, 1, 1, 6);  hw_mem[3]  = 16'hA002;
    hw_mem[4]  = mk(1, 0, 1, 7);  hw_mem[5]  = 16'hA003;
    hw_mem[6]  = mk(1, 3, 0, 8);  hw_mem[7]  = 16'hA004;
    hw_mem[8]  = mk(1, 1, 0, 9);  hw_mem[9]  = 16'hA005;
    hw_mem[10] = mk(1, 0, 0, 10); hw_mem[11] = 16'hA006;
    hw_mem[12] = mk(0, 0, 0, 11);
    hw_mem[13] = mk(0, 1, 0, 12);
    hw_mem[14] = mk(0, 2, 0, 13);
    hw_mem[15] = mk(1, 0, 1, 14); hw_mem[16] = 16'hB00B;
    for (int i = 17; i < 32; i++) hw_mem[i] = mk(0, i % 3, 1'((i / 3) % 2), i);
    run_stream(2, NOBRK, 0, "lanes-and-split");
    chk(exp_v[0] == 6'h3f, "R4", "model full group of six", 192'(exp_v[0]), 192'(6'h3f));

    // R9: same stream, fetch pauses after the first packet
    run_stream(2, 16, 0, "drain-pause");

    // R7: output stalled, queue must stop taking packets
    for (int i = 0; i < 48; i++) hw_mem[i] = mk(0, 1, 1, i);
    run_stream(3, NOBRK, 10, "backpressure");

    // R10: flush with data queued and a packet offered in the same cycle
    for (int i = 0; i < 32; i++) hw_mem[i] = mk(0, 2, 0, i);
    @(negedge clk);
    in_valid = 1;
    for (int k = 0; k < 16; k++) in_pkt[k*16 +: 16] = hw_mem[k];
    out_ready = 0;
    @(negedge clk);
    @(negedge clk);
    flush = 1;
    for (int k = 0; k < 16; k++) in_pkt[k*16 +: 16] = hw_mem[16 + k];
    @(negedge clk);
    flush = 0;
    in_valid = 0;
    chk(!out_valid && in_ready, "R10", "state after flush",
        192'({out_valid, in_ready}), 192'(1));
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid, "R10", "nothing stale drains after flush", 192'(out_valid), 192'(0));
    gen_stream(2, 0);
    run_stream(2, NOBRK, 0, "after-flush");

    // constrained random streams
    gen_stream(8, 0); run_stream(8, NOBRK, 0, "rand-mixed");
    gen_stream(8, 1); run_stream(8, NOBRK, 0, "rand-long");
    gen_stream(8, 2); run_stream(8, NOBRK, 0, "rand-conflict");
    gen_stream(6, 0); run_stream(6, 48, 0, "rand-pause");

    finish_run();
  end
endmodule